// File: doc/BRIEF.md
# Three-Wire Latched Serial Control Port

This block takes control words from a three-wire serial link: a serial clock, a data line and a latch enable. Bits enter a 23-bit shift register on each rising serial-clock edge, most significant bit first. When latch enable rises, the shift register is copied into one of two holding registers. The bit shifted in last is the selector between them: a 1 selects the feedback-divider register, which holds a 13-bit main count and a 5-bit swallow count, and a 0 selects the 11-bit reference-divider register.

All three serial inputs are treated as asynchronous. Each passes through a two-flop synchronizer into the system clock domain, and serial-clock and latch-enable edges are detected there. A serial clock phase must therefore last at least three system clock periods. Each holding register has a one-cycle update strobe that is raised in the same cycle its new contents appear.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset, the main count, swallow count and reference value outputs are all zero and both strobes are low.
- R2: Bits are shifted in MSB first. Number the word bits 22 (first sent) down to 0 (last sent). When bit 0 is 1, a latch loads the main count from bits 22..10 and the swallow count from bits 9..5.
- R3: When bit 0 of the word is 0, a latch loads the reference value from bits 11..1.
- R4: A holding register changes only on a latch-enable rising edge that selects it. The unselected register keeps its value.
- R5: Each latch raises exactly one strobe, the one for the selected register, for exactly one system clock cycle. The two strobes are never high together.
- R6: While latch enable is high, serial clock edges and data are ignored, so the shift register keeps its contents.
- R7: A latch is applied whatever number of bits was shifted since the previous latch. It uses the last 23 bits held in the shift register, including bits left over from earlier words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdata_i | input | 1 | Serial data, sampled on a serial clock rising edge |
| le_i | input | 1 | Latch enable; a rising edge transfers the word |
| fb_main_o | output | 13 | Feedback main count |
| fb_swallow_o | output | 5 | Feedback swallow count |
| ref_div_o | output | 11 | Reference divider value |
| fb_upd_o | output | 1 | One-cycle strobe on a feedback register update |
| ref_upd_o | output | 1 | One-cycle strobe on a reference register update |

## Verification
Some properties are checked on every cycle:
- A holding register never changes without its strobe.
- Every strobe follows a detected latch-enable edge.
- The two strobes are exclusive, and each lasts one cycle.

Other behaviour can only be shown through the bench's scenarios: MSB-first bit placement, field extraction for each selector value, freezing of the shifter while latch enable is high, and latches after short or overlong bit counts. For these, the bench keeps its own model of the shift register and predicts each update.

// File: rtl/ctl_port_pkg.sv
// Package: shared widths for the serial control port.
// Assumes: the word is split MSB-first into main, swallow, spare and selector bits.
package ctl_port_pkg;
    parameter int WORD_W    = 23;
    parameter int MAIN_W    = 13;
    parameter int SWAL_W    = 5;
    parameter int REF_W     = 11;
    parameter int SYNC_DEPTH = 2;

    localparam int MAIN_LSB = WORD_W - MAIN_W;
    localparam int SWAL_LSB = MAIN_LSB - SWAL_W;
    localparam int REF_LSB  = 1;

    typedef struct packed {
        logic [MAIN_W-1:0] main_cnt;
        logic [SWAL_W-1:0] swal_cnt;
    } fb_set_t;
endpackage

// File: rtl/ctl_sync.sv
// Module: ctl_sync
// Brings a vector of asynchronous single-bit inputs into the clk domain.
// Assumes: each bit is independent; no bus coherency is required.
module ctl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain_q[g] <= '0;
                else if (g == 0) chain_q[g] <= async_i;
                else             chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_shift.sv
// Module: ctl_shift
// Finds serial-clock and latch-enable rising edges and shifts data MSB first.
// Assumes: inputs are already synchronized; shifting stops while latch is high.
module ctl_shift #(
    parameter int WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              le_s,
    output logic [WORD_W-1:0] word_o,
    output logic              le_rise_o
);
    logic sclk_q;
    logic le_q;
    logic sclk_rise;

    // Purpose: remember the last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            le_q   <= le_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign le_rise_o = le_s & ~le_q;

    // Purpose: shift one bit in at the LSB on a serial clock rise, frozen while latch is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                  word_o <= '0;
        else if (sclk_rise && !le_s) word_o <= {word_o[WORD_W-2:0], sdata_s};
    end
endmodule

// File: rtl/ctl_latch.sv
// Module: ctl_latch
// Routes the shifted word to one of two holding registers, chosen by word bit 0.
// Assumes: a single-cycle load request from the edge detector.
module ctl_latch
    import ctl_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              load_i,
    output fb_set_t           fb_o,
    output logic [REF_W-1:0]  ref_o,
    output logic              fb_upd_o,
    output logic              ref_upd_o
);
    logic sel_fb;
    assign sel_fb = word_i[0];

    // Purpose: load the selected holding register and pulse its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_o      <= '0;
            ref_o     <= '0;
            fb_upd_o  <= 1'b0;
            ref_upd_o <= 1'b0;
        end else begin
            fb_upd_o  <= load_i &  sel_fb;
            ref_upd_o <= load_i & ~sel_fb;
            if (load_i && sel_fb) begin
                fb_o.main_cnt <= word_i[WORD_W-1:MAIN_LSB];
                fb_o.swal_cnt <= word_i[MAIN_LSB-1:SWAL_LSB];
            end
            if (load_i && !sel_fb) begin
                ref_o <= word_i[REF_LSB+REF_W-1:REF_LSB];
            end
        end
    end
endmodule

// File: rtl/serial_ctrl_port.sv
// Module: serial_ctrl_port (top)
// Three-wire serial receiver feeding feedback and reference divider settings.
// Assumes: each serial clock phase lasts at least three clk periods.
module serial_ctrl_port
    import ctl_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              le_i,
    output logic [MAIN_W-1:0] fb_main_o,
    output logic [SWAL_W-1:0] fb_swallow_o,
    output logic [REF_W-1:0]  ref_div_o,
    output logic              fb_upd_o,
    output logic              ref_upd_o
);
    logic [2:0]        pins_s;
    logic [WORD_W-1:0] word;
    logic              le_rise;
    fb_set_t           fb_set;

    ctl_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({le_i, sdata_i, sclk_i}),
        .sync_o  (pins_s)
    );

    ctl_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[0]),
        .sdata_s   (pins_s[1]),
        .le_s      (pins_s[2]),
        .word_o    (word),
        .le_rise_o (le_rise)
    );

    ctl_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_i    (word),
        .load_i    (le_rise),
        .fb_o      (fb_set),
        .ref_o     (ref_div_o),
        .fb_upd_o  (fb_upd_o),
        .ref_upd_o (ref_upd_o)
    );

    assign fb_main_o    = fb_set.main_cnt;
    assign fb_swallow_o = fb_set.swal_cnt;
endmodule

// File: rtl/serial_ctrl_port_chk.sv
// Module: serial_ctrl_port_chk
// Cycle-by-cycle properties of the control port, bound to the top module.
module serial_ctrl_port_chk
    import ctl_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MAIN_W-1:0] fb_main,
    input logic [SWAL_W-1:0] fb_swal,
    input logic [REF_W-1:0]  ref_div,
    input logic              fb_upd,
    input logic              ref_upd,
    input logic              le_rise
);
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fb_upd && ref_upd)); // R5
    AST_FB_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_upd |=> !fb_upd); // R5
    AST_REF_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |=> !ref_upd); // R5
    AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({fb_main, fb_swal}) |-> fb_upd); // R4
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_div) |-> ref_upd); // R4
    AST_UPD_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_upd || ref_upd) |-> $past(le_rise)); // R4
endmodule

bind serial_ctrl_port serial_ctrl_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fb_main (fb_main_o),
    .fb_swal (fb_swallow_o),
    .ref_div (ref_div_o),
    .fb_upd  (fb_upd_o),
    .ref_upd (ref_upd_o),
    .le_rise (le_rise)
);

// File: tb/serial_ctrl_port_bench.sv
// Scoreboard bench: the driver predicts each update, the monitor compares on strobes.
module serial_ctrl_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic le = 1'b0;
    logic [12:0] fb_main;
    logic [4:0]  fb_swal;
    logic [10:0] ref_div;
    logic        fb_upd;
    logic        ref_upd;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          is_fb;
        logic [12:0] m;
        logic [4:0]  s;
        logic [10:0] r;
    } exp_t;
    exp_t exp_q[$];

    logic [22:0] model_sr = '0;
    logic [12:0] model_m  = '0;
    logic [4:0]  model_s  = '0;
    logic [10:0] model_r  = '0;

    always #10 clk = ~clk;

    serial_ctrl_port u_serial_ctrl_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk),
        .sdata_i      (sdata),
        .le_i         (le),
        .fb_main_o    (fb_main),
        .fb_swallow_o (fb_swal),
        .ref_div_o    (ref_div),
        .fb_upd_o     (fb_upd),
        .ref_upd_o    (ref_upd)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sdata = b;
        tick(3);
        sclk = 1'b1;
        model_sr = {model_sr[21:0], b};
        tick(3);
        sclk = 1'b0;
    endtask

    task automatic send(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    endtask

    // Predict the update from the model shift register (R2, R3, R4).
    task automatic push_expect();
        exp_t e;
        if (model_sr[0]) begin
            model_m = model_sr[22:10];
            model_s = model_sr[9:5];
        end else begin
            model_r = model_sr[11:1];
        end
        e.is_fb = model_sr[0];
        e.m = model_m;
        e.s = model_s;
        e.r = model_r;
        exp_q.push_back(e);
    endtask

    task automatic latch();
        push_expect();
        le = 1'b1;
        tick(6);
        le = 1'b0;
        tick(4);
    endtask

    // Latch, then toggle the serial clock and data while latch is high (R6).
    task automatic latch_with_noise();
        push_expect();
        le = 1'b1;
        tick(5);
        for (int i = 0; i < 4; i++) begin
            sdata = ~sdata;
            tick(3);
            sclk = 1'b1;
            tick(3);
            sclk = 1'b0;
        end
        tick(3);
        le = 1'b0;
        tick(4);
    endtask

    function automatic logic [22:0] fb_word(input logic [12:0] m, input logic [4:0] s);
        return {m, s, 4'b1010, 1'b1};
    endfunction

    function automatic logic [22:0] ref_word(input logic [10:0] r);
        return {10'h2A5, r, 1'b0};
    endfunction

    // Monitor: compare every strobe against the scoreboard.
    logic prev_strobe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_strobe) begin
                checks++;
                if (fb_upd || ref_upd) begin
                    errors++;
                    $display("FAIL R5: strobe held two cycles fb=%0b ref=%0b expected 0 0", fb_upd, ref_upd);
                end
            end
            if (fb_upd || ref_upd) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4: unexpected strobe fb=%0b ref=%0b expected none", fb_upd, ref_upd);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (fb_upd !== e.is_fb || ref_upd !== !e.is_fb || fb_main !== e.m ||
                        fb_swal !== e.s || ref_div !== e.r) begin
                        errors++;
                        $display("FAIL R2/R3/R5: got fb=%0b ref=%0b m=%0h s=%0h r=%0h expected fb=%0b m=%0h s=%0h r=%0h",
                                 fb_upd, ref_upd, fb_main, fb_swal, ref_div, e.is_fb, e.m, e.s, e.r);
                    end
                end
            end
            prev_strobe <= fb_upd || ref_upd;
        end
    end

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        checks++;
        if (fb_main !== '0 || fb_swal !== '0 || ref_div !== '0 || fb_upd !== 1'b0 || ref_upd !== 1'b0) begin
            errors++;
            $display("FAIL R1: m=%0h s=%0h r=%0h fb=%0b ref=%0b expected all zero", fb_main, fb_swal, ref_div, fb_upd, ref_upd);
        end
        // R2: feedback word, MSB first
        send(23, {9'b0, fb_word(13'h1ABC, 5'h13)});
        latch();
        // R3: reference word; the feedback register must stay unchanged (R4)
        send(23, {9'b0, ref_word(11'h5A3)});
        latch();
        // R2: extremes of the fields
        send(23, {9'b0, fb_word(13'h1FFF, 5'h00)});
        latch();
        send(23, {9'b0, ref_word(11'h7FF)});
        latch();
        send(23, {9'b0, fb_word(13'h0020, 5'h1F)});
        // R6: latch with serial activity while latch is high, then relatch the same contents
        latch_with_noise();
        latch();
        // R7: short update, five bits on top of the previous contents
        send(5, 32'b10110);
        latch();
        // R7: long update, 27 bits, only the last 23 count
        send(27, {5'b0, 4'b1011, ref_word(11'h123)});
        latch();
        send(4, 32'b0111);
        latch();
        tick(10);
        // R4: every predicted update was observed
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4: %0d updates missing, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule